// File: doc/BRIEF.md
# ChaCha Block XOR Engine

This engine produces one 64-byte ChaCha block and applies it to a data block. The caller supplies a fully formatted sixteen-word starting state, which holds the constants, key, counter and nonce. It also supplies 64 bytes of data and an even, non-zero round count, and pulses `start`. The engine runs one column or one diagonal round in each clock cycle, so a pair of rounds takes two cycles. It then adds the saved starting state back into the working state, word by word, modulo 2^32. Finally it XORs that keystream into the data. The same operation encrypts and decrypts.

The control is a four-state machine:
- `ST_IDLE` waits for `start`.
  - A start with a valid round count moves it to `ST_COLUMN` and latches the state, the data and the count.
  - A start with an invalid count stays in `ST_IDLE` and raises `err` for one cycle.
- `ST_COLUMN` always moves to `ST_DIAGONAL`.
- `ST_DIAGONAL` lowers the remaining count by two.
  - It returns to `ST_COLUMN` while pairs remain.
  - It moves to `ST_FINISH` after the last pair.
- `ST_FINISH` writes the result, pulses `done` and goes back to `ST_IDLE`.

Top module: `chacha_xor_core`

## Requirements
- R1: `data_out` equals (P(S) + S) XOR D, where S is the starting state, D is the data, P is the permutation of R rounds and + is a per-word sum modulo 2^32. An all-zero state gives a zero keystream, so `data_out` equals D.
- R2: Each quarter-round on (a,b,c,d) computes, in this order:
  - a += b, then d = rotl(d^a,16)
  - c += d, then b = rotl(b^c,12)
  - a += b, then d = rotl(d^a,8)
  - c += d, then b = rotl(b^c,7)
  
  Odd rounds use the column groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). Even rounds use the diagonal groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). The permutation runs R/2 column-plus-diagonal pairs, so R = 2, 8, 12 and 20 each give distinct results.
- R3: Word i of every 512-bit bus occupies bits [32i+31:32i]. Byte j of a block occupies bits [8j+7:8j], so byte 0 is the least significant byte of word 0.
- R4: When a valid start is sampled at clock edge E, `done` is high in the cycle after edge E+R+1. That is R+2 sampled cycles after the start.
- R5: `done` is high for exactly one cycle. `data_out` changes only in a cycle where `done` is high, and it holds its value until the next completion.
- R6: A start in `ST_IDLE` with R = 0 or R odd is rejected.
  - `err` is high for the one cycle after that start.
  - `busy` stays low and `done` does not rise.
  - `data_out` is unchanged.
- R7: A `start` sampled while `busy` is high is ignored. The running job completes with its original inputs, and `err` does not rise.
- R8: While `rst_n` is low, `busy`, `done` and `err` are 0 and `data_out` is all zeros.
- R9: After a valid start, `busy` is high from the next cycle until the result is written. `busy` is low in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a block; sampled only in `ST_IDLE` |
| rounds | input | ROUND_W | Round count; must be even and non-zero |
| state_in | input | 512 | Starting state; word i at bits [32i+31:32i] |
| data_in | input | 512 | Data block, little-endian words |
| busy | output | 1 | High while a job runs |
| done | output | 1 | One-cycle pulse; `data_out` is new |
| err | output | 1 | One-cycle pulse after a rejected start |
| data_out | output | 512 | Data XOR keystream, held until the next completion |

## Verification
The bound checker covers the handshake on every cycle:
- the single-cycle width of `done` and `err`;
- the stability of `data_out` between completions;
- the immediate `err` after a bad round count, with `busy` staying low;
- `busy` rising after a good start;
- no error raised by a start that arrives during a run.

Only the bench scenarios can show that the arithmetic is right, by comparing against an independent model. The model covers random states, the column and diagonal grouping, several round counts and byte placement. The scenarios also show the exact latency and that a start during a run leaves the running result untouched.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

    localparam int WORD_W  = 32;
    localparam int N_WORDS = 16;
    localparam int BLK_W   = WORD_W * N_WORDS;
    localparam int N_QR    = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLUMN,
        ST_DIAGONAL,
        ST_FINISH
    } core_state_e;

    function automatic word_t rotl(input word_t v, input int unsigned n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

    // Word index of row 'row' in quarter-round lane 'lane'.
    // In the diagonal phase each row is shifted left by its row number.
    function automatic logic [3:0] grp_idx(input logic [1:0] lane,
                                           input logic [1:0] row,
                                           input logic       diag);
        logic [1:0] col;
        col = lane + (diag ? row : 2'd0);
        return {row, col};
    endfunction

endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
    import chacha_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);

    word_t a1, b1, c1, d1;
    word_t a2, b2, c2, d2;

    always_comb begin
        a1 = a_i + b_i;
        d1 = rotl(d_i ^ a1, 16);
        c1 = c_i + d1;
        b1 = rotl(b_i ^ c1, 12);
        a2 = a1 + b1;
        d2 = rotl(d1 ^ a2, 8);
        c2 = c1 + d2;
        b2 = rotl(b1 ^ c2, 7);
    end

    assign a_o = a2;
    assign b_o = b2;
    assign c_o = c2;
    assign d_o = d2;

endmodule

// File: rtl/chacha_round.sv
module chacha_round
    import chacha_pkg::*;
(
    input  logic  diag_i,
    input  word_t w_i [N_WORDS],
    output word_t w_o [N_WORDS]
);

    word_t ga [N_QR];
    word_t gb [N_QR];
    word_t gc [N_QR];
    word_t gd [N_QR];
    word_t qa [N_QR];
    word_t qb [N_QR];
    word_t qc [N_QR];
    word_t qd [N_QR];

    // Gather the four words of each lane.
    always_comb begin
        for (int k = 0; k < N_QR; k++) begin
            ga[k] = w_i[grp_idx(2'(k), 2'd0, diag_i)];
            gb[k] = w_i[grp_idx(2'(k), 2'd1, diag_i)];
            gc[k] = w_i[grp_idx(2'(k), 2'd2, diag_i)];
            gd[k] = w_i[grp_idx(2'(k), 2'd3, diag_i)];
        end
    end

    for (genvar k = 0; k < N_QR; k++) begin : g_lane
        chacha_qr u_qr (
            .a_i (ga[k]),
            .b_i (gb[k]),
            .c_i (gc[k]),
            .d_i (gd[k]),
            .a_o (qa[k]),
            .b_o (qb[k]),
            .c_o (qc[k]),
            .d_o (qd[k])
        );
    end

    // Scatter the results back to the same positions.
    always_comb begin
        w_o = w_i;
        for (int k = 0; k < N_QR; k++) begin
            w_o[grp_idx(2'(k), 2'd0, diag_i)] = qa[k];
            w_o[grp_idx(2'(k), 2'd1, diag_i)] = qb[k];
            w_o[grp_idx(2'(k), 2'd2, diag_i)] = qc[k];
            w_o[grp_idx(2'(k), 2'd3, diag_i)] = qd[k];
        end
    end

endmodule

// File: rtl/chacha_xor_core.sv
module chacha_xor_core
    import chacha_pkg::*;
#(
    parameter int ROUND_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ROUND_W-1:0] rounds,
    input  logic [BLK_W-1:0]   state_in,
    input  logic [BLK_W-1:0]   data_in,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [BLK_W-1:0]   data_out
);

    localparam logic [ROUND_W-1:0] PAIR = ROUND_W'(2);

    core_state_e        state_q, state_d;
    word_t              work_q    [N_WORDS];
    word_t              orig_q    [N_WORDS];
    word_t              round_out [N_WORDS];
    logic [BLK_W-1:0]   data_q;
    logic [ROUND_W-1:0] cnt_q;
    logic               rounds_ok;
    logic               accept;
    logic               reject;

    assign rounds_ok = (rounds != '0) && !rounds[0];
    assign accept    = start && (state_q == ST_IDLE) && rounds_ok;
    assign reject    = start && (state_q == ST_IDLE) && !rounds_ok;
    assign busy      = (state_q != ST_IDLE);

    chacha_round u_round (
        .diag_i (state_q == ST_DIAGONAL),
        .w_i    (work_q),
        .w_o    (round_out)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_COLUMN;
            ST_COLUMN:   state_d = ST_DIAGONAL;
            ST_DIAGONAL: state_d = (cnt_q == PAIR) ? ST_FINISH : ST_COLUMN;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++) begin
                work_q[i] <= '0;
                orig_q[i] <= '0;
            end
            data_q   <= '0;
            cnt_q    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            data_out <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        for (int i = 0; i < N_WORDS; i++) begin
                            work_q[i] <= state_in[WORD_W*i +: WORD_W];
                            orig_q[i] <= state_in[WORD_W*i +: WORD_W];
                        end
                        data_q <= data_in;
                        cnt_q  <= rounds;
                    end
                    err <= reject;
                end
                ST_COLUMN: begin
                    work_q <= round_out;
                end
                ST_DIAGONAL: begin
                    work_q <= round_out;
                    cnt_q  <= cnt_q - PAIR;
                end
                ST_FINISH: begin
                    for (int i = 0; i < N_WORDS; i++) begin
                        data_out[WORD_W*i +: WORD_W] <=
                            (work_q[i] + orig_q[i]) ^ data_q[WORD_W*i +: WORD_W];
                    end
                    done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/chacha_xor_chk.sv
module chacha_xor_chk
    import chacha_pkg::*;
#(
    parameter int ROUND_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [ROUND_W-1:0] rounds,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [BLK_W-1:0]   data_out
);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(data_out));

    // R6
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((rounds == '0) || rounds[0])) |=> (err && !busy && !done));

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !err);

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (rounds != '0) && !rounds[0]) |=> busy);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind chacha_xor_core chacha_xor_chk #(.ROUND_W(ROUND_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rounds   (rounds),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .data_out (data_out)
);

// File: tb/sim_chacha_xor_core.sv
module sim_chacha_xor_core;

    localparam int RW = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [RW-1:0]  rounds;
    logic [511:0]   state_in;
    logic [511:0]   data_in;
    logic           busy;
    logic           done;
    logic           err;
    logic [511:0]   data_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    chacha_xor_core #(.ROUND_W(RW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rounds   (rounds),
        .state_in (state_in),
        .data_in  (data_in),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .data_out (data_out)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    // {a,b,c,d} in, {a,b,c,d} out
    function automatic logic [127:0] qr_ref(input logic [127:0] q);
        logic [31:0] a, b, c, d;
        {a, b, c, d} = q;
        a = a + b; d = rl(d ^ a, 16);
        c = c + d; b = rl(b ^ c, 12);
        a = a + b; d = rl(d ^ a, 8);
        c = c + d; b = rl(b ^ c, 7);
        return {a, b, c, d};
    endfunction

    function automatic logic [511:0] ref_block(input logic [511:0] st,
                                               input logic [511:0] dat,
                                               input int r);
        logic [31:0]  x [16];
        logic [511:0] res;
        int g [8][4] = '{'{0, 4, 8, 12}, '{1, 5, 9, 13}, '{2, 6, 10, 14}, '{3, 7, 11, 15},
                         '{0, 5, 10, 15}, '{1, 6, 11, 12}, '{2, 7, 8, 13}, '{3, 4, 9, 14}};
        for (int i = 0; i < 16; i++) x[i] = st[32*i +: 32];
        for (int p = 0; p < r / 2; p++) begin
            for (int k = 0; k < 8; k++) begin
                {x[g[k][0]], x[g[k][1]], x[g[k][2]], x[g[k][3]]} =
                    qr_ref({x[g[k][0]], x[g[k][1]], x[g[k][2]], x[g[k][3]]});
            end
        end
        for (int i = 0; i < 16; i++)
            res[32*i +: 32] = (x[i] + st[32*i +: 32]) ^ dat[32*i +: 32];
        return res;
    endfunction

    function automatic logic [511:0] rand_blk();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom();
        return v;
    endfunction

    // Drive a job; optionally poke a second start mid-run.
    task automatic run_job(input logic [511:0] st, input logic [511:0] dat,
                           input int r, input bit poke,
                           output logic [511:0] res, output int lat,
                           output bit busy1, output bit err_seen);
        int cyc = 0;
        err_seen = 1'b0;
        busy1    = 1'b0;
        @(negedge clk);
        state_in = st;
        data_in  = dat;
        rounds   = RW'(r);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        busy1 = busy;
        while (!done && cyc < 600) begin
            if (poke && cyc == 3) begin
                state_in = rand_blk();
                data_in  = rand_blk();
                rounds   = 8'd4;
                start    = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (err) err_seen = 1'b1;
        end
        start = 1'b0;
        lat   = cyc;
        res   = data_out;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [511:0] st, dat, res, exp, held;
        int lat;
        bit b1, es;
        int rset [4] = '{2, 8, 12, 20};

        void'($urandom(32'd90210));
        rst_n    = 1'b0;
        start    = 1'b0;
        rounds   = '0;
        state_in = '0;
        data_in  = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(!busy && !done && !err, "R8 flags in reset", {busy, done, err}, 0);
        chk(data_out == '0, "R8 data_out in reset", data_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 zero state gives zero keystream
        dat = rand_blk();
        run_job('0, dat, 20, 0, res, lat, b1, es);
        chk(res == dat, "R1 zero state passthrough", res, dat);

        // R2 each round count gives its own result
        st  = rand_blk();
        dat = rand_blk();
        for (int j = 0; j < 4; j++) begin
            exp = ref_block(st, dat, rset[j]);
            run_job(st, dat, rset[j], 0, res, lat, b1, es);
            chk(res == exp, "R2 round count result", res, exp);
            // R4 latency
            chk(lat == rset[j] + 2, "R4 latency", 512'(lat), 512'(rset[j] + 2));
            // R9 busy after start
            chk(b1, "R9 busy after start", 512'(b1), 1);
        end
        chk(ref_block(st, dat, 2) != ref_block(st, dat, 8), "R2 distinct counts",
            ref_block(st, dat, 2), ref_block(st, dat, 8));

        // R3 byte placement: single bit in word 0, byte-wise compare
        st  = '0;
        st[0] = 1'b1;
        dat = '0;
        for (int j = 0; j < 64; j++) dat[8*j +: 8] = 8'(j);
        exp = ref_block(st, dat, 8);
        run_job(st, dat, 8, 0, res, lat, b1, es);
        for (int j = 0; j < 64; j += 9)
            chk(res[8*j +: 8] == exp[8*j +: 8], "R3 byte lane", 512'(res[8*j +: 8]),
                512'(exp[8*j +: 8]));

        // R1 random jobs
        for (int n = 0; n < 10; n++) begin
            int r;
            st  = rand_blk();
            dat = rand_blk();
            r   = 2 * (1 + int'($urandom_range(0, 9)));
            exp = ref_block(st, dat, r);
            run_job(st, dat, r, 0, res, lat, b1, es);
            chk(res == exp, "R1 random block", res, exp);
            chk(lat == r + 2, "R4 random latency", 512'(lat), 512'(r + 2));
        end

        // R1 long round count
        st  = rand_blk();
        dat = rand_blk();
        exp = ref_block(st, dat, 254);
        run_job(st, dat, 254, 0, res, lat, b1, es);
        chk(res == exp, "R1 254 rounds", res, exp);

        // R7 start during busy ignored
        st  = rand_blk();
        dat = rand_blk();
        exp = ref_block(st, dat, 12);
        run_job(st, dat, 12, 1, res, lat, b1, es);
        chk(res == exp, "R7 busy start ignored", res, exp);
        chk(lat == 14, "R7 latency unchanged", 512'(lat), 14);
        chk(!es, "R7 no err", 512'(es), 0);

        // R5 done pulse one cycle and output held
        held = data_out;
        @(negedge clk);
        chk(!done, "R5 done single cycle", 512'(done), 0);
        repeat (5) @(negedge clk);
        chk(data_out == held, "R5 output held", data_out, held);

        // R6 rejection for zero and odd counts
        for (int j = 0; j < 2; j++) begin
            bit saw_done = 1'b0;
            held = data_out;
            @(negedge clk);
            state_in = rand_blk();
            data_in  = rand_blk();
            rounds   = (j == 0) ? 8'd0 : 8'd7;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(err && !busy, "R6 err flagged", {err, busy}, 2'b10);
            @(negedge clk);
            chk(!err, "R6 err one cycle", 512'(err), 0);
            repeat (20) begin
                @(negedge clk);
                if (done || busy) saw_done = 1'b1;
            end
            chk(!saw_done, "R6 no run", 512'(saw_done), 0);
            chk(data_out == held, "R6 output unchanged", data_out, held);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule